// File: doc/BRIEF.md
# String Port Output Step Unit

This unit performs a single step of a string-to-port output operation for a core that runs legacy code. It takes one request through a ready/valid handshake. The request carries a 16-bit port number, the data, an operand size, the privilege and mode flags, and the permission-bitmap bits that an outside lookup has already fetched for the port. The unit first decides whether the access is allowed. It then forms the 64-bit virtual address where the port lives, and rejects addresses that cannot be used.

When the access is allowed, the unit brackets the port write with two memory fences. It issues the write and hands back the index register, moved by the operand size in the direction that the direction flag selects. When the access is denied, the unit emits a one-cycle fault strobe with error code 0. It touches neither memory nor the index.

The unit does not hold the bitmap itself and does not translate addresses. Both of those jobs sit outside the block.

Top module: `spout_unit`

## Requirements
- R1: The permission test applies only when `prot_en` is 1 and either `v86_en` is 1 or `cpl` is numerically greater than `iopl`. Otherwise the access is allowed whatever the bitmap bits hold.
- R2: When the permission test applies and `io_chk_en` is 0, the access is allowed even if bitmap bits are set.
- R3: When the permission test applies and `io_chk_en` is 1, the unit examines bit i of `req_bmp`, which covers port byte `req_port`+i. Byte size (`req_size`=0) looks at bit 0. Word size (1) looks at bits 1:0. Doubleword size (2, and also 3) looks at bits 3:0. If any examined bit is 1, the access faults.
- R4: The write address is `io_base` OR (`req_port`[15:2] shifted left 12) OR `req_port`[11:0]. This gives four ports per 4 KiB page. `wr_data` and `wr_size` carry the request's data and size.
- R5: The access faults when `xlat_en` is 0, or when any address bit at or above `IMPL_VA_W` (default 48) is 1.
- R6: Before the write, the unit raises `fence_req` and waits for `fence_done`. After the write, it raises `fence_req` again and waits for `fence_done` before it presents the index result. `wr_valid` never rises before the first fence has completed.
- R7: The index result is `req_idx` moved by 1 for byte size, 2 for word size and 4 for doubleword size. It moves upward when `req_dir` is 0 and downward when `req_dir` is 1. It is valid for one cycle with `idx_valid`.
- R8: `req_ready` is 1 only while the unit is idle. A held write (`wr_valid` with `wr_ready` low) keeps its address and data stable.
- R9: A fault is a single-cycle `fault_valid` pulse with `fault_code` 0. It comes with no write, no fence and no `idx_valid`, and the unit returns to idle afterwards.
- R10: After reset, or on reset during an operation, the unit is idle: `req_ready` is 1 and `fault_valid`, `fence_req`, `wr_valid` and `idx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken |
| req_port | input | 16 | Port number |
| req_data | input | DATA_W | Data to write |
| req_size | input | 2 | 0 byte, 1 word, 2/3 doubleword |
| req_dir | input | 1 | Direction flag, 1 = downward |
| req_idx | input | IDX_W | Current index value |
| req_bmp | input | 4 | Bitmap bits for ports req_port+0..3 |
| prot_en | input | 1 | Protected mode enabled |
| v86_en | input | 1 | Virtual-8086 mode active |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| io_chk_en | input | 1 | Bitmap consultation enabled |
| xlat_en | input | 1 | Data translation enabled |
| io_base | input | 64 | I/O base address |
| fault_valid | output | 1 | Fault strobe |
| fault_code | output | 16 | Fault error code |
| fence_req | output | 1 | Fence request |
| fence_done | input | 1 | Fence completed |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 64 | Write virtual address |
| wr_data | output | DATA_W | Write data |
| wr_size | output | 2 | Write size |
| idx_valid | output | 1 | Index result valid |
| idx_out | output | IDX_W | Updated index |

## Verification
A vector table covers several input patterns.

- Real-mode requests with all bitmap bits set show that the privilege gate bypasses the bitmap.
- Requests where the privilege level is above the I/O level, and requests in virtual-8086 mode, show that the gate does engage.
- Set bitmap bits placed just inside and just outside the size mask separate the byte, word and doubleword coverage.
- Requests with the check-enable bit cleared show that the bitmap is skipped.
- Translation-off requests and a base with a high bit set exercise the address faults.
- The highest port number, both directions and all three sizes check the address packing and the index step.

Directed tests then stretch the fence latency, stall the write, and assert reset in the middle of an operation.

// File: rtl/spout_pkg.sv
package spout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FENCE_PRE,
    ST_WRITE,
    ST_FENCE_POST,
    ST_UPDATE
  } spout_state_e;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  // Size code 3 is treated as doubleword.
  function automatic logic [1:0] eff_size(input logic [1:0] sz);
    return (sz == 2'd3) ? SZ_DWORD : sz;
  endfunction

endpackage

// File: rtl/spout_perm.sv
module spout_perm
  import spout_pkg::*;
#(
  parameter int PL_W = 2,
  parameter int BM_W = 4
) (
  input  logic            prot_en,
  input  logic            v86_en,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] iopl,
  input  logic            io_chk_en,
  input  logic [1:0]      size,
  input  logic [BM_W-1:0] bmp,
  output logic            deny
);

  logic [1:0]      sz;
  logic [BM_W-1:0] mask;
  logic            gated;

  assign sz = eff_size(size);

  // Bitmap bit i covers port byte i of the access.
  for (genvar i = 0; i < BM_W; i++) begin : g_mask
    assign mask[i] = (i < (1 << sz));
  end

  assign gated = prot_en && (v86_en || (cpl > iopl));
  assign deny  = gated && io_chk_en && |(bmp & mask);

endmodule

// File: rtl/spout_addr.sv
module spout_addr #(
  parameter int VA_W      = 64,
  parameter int IMPL_VA_W = 48
) (
  input  logic [VA_W-1:0] io_base,
  input  logic [15:0]     port,
  input  logic            xlat_en,
  output logic [VA_W-1:0] va,
  output logic            bad
);

  localparam int PAGE_SH = 12;

  logic [VA_W-1:0] page_part;
  logic [VA_W-1:0] off_part;
  logic            hi_set;

  assign page_part = {{(VA_W-PAGE_SH-14){1'b0}}, port[15:2], {PAGE_SH{1'b0}}};
  assign off_part  = {{(VA_W-PAGE_SH){1'b0}}, port[PAGE_SH-1:0]};
  assign va        = io_base | page_part | off_part;

  if (IMPL_VA_W >= VA_W) begin : g_full
    assign hi_set = 1'b0;
  end else begin : g_part
    assign hi_set = |va[VA_W-1:IMPL_VA_W];
  end

  assign bad = !xlat_en || hi_set;

endmodule

// File: rtl/spout_idx.sv
module spout_idx
  import spout_pkg::*;
#(
  parameter int IDX_W = 32
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  input  logic             dir,
  output logic [IDX_W-1:0] idx_nxt
);

  logic [IDX_W-1:0] step;

  assign step    = IDX_W'(1) << eff_size(size);
  assign idx_nxt = dir ? (idx - step) : (idx + step);

endmodule

// File: rtl/spout_unit.sv
module spout_unit
  import spout_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 32,
  parameter int IMPL_VA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_port,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        req_size,
  input  logic              req_dir,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [3:0]        req_bmp,
  input  logic              prot_en,
  input  logic              v86_en,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic              io_chk_en,
  input  logic              xlat_en,
  input  logic [63:0]       io_base,
  output logic              fault_valid,
  output logic [15:0]       fault_code,
  output logic              fence_req,
  input  logic              fence_done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [63:0]       wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [1:0]        wr_size,
  output logic              idx_valid,
  output logic [IDX_W-1:0]  idx_out
);

  localparam int VA_W = 64;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  spout_state_e state_q, state_d;

  logic              take;
  logic [15:0]       port_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        size_q;
  logic              dir_q, prot_q, v86_q, chk_q, xlat_q;
  logic [IDX_W-1:0]  idx_q;
  logic [3:0]        bmp_q;
  logic [1:0]        cpl_q, iopl_q;
  logic [VA_W-1:0]   base_q;

  logic              deny, bad;
  logic [VA_W-1:0]   va;
  logic [IDX_W-1:0]  idx_nxt;
  logic              fault;

  assign take = (state_q == ST_IDLE) && req_valid;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      port_q <= '0; data_q <= '0; size_q <= '0; dir_q <= 1'b0;
      idx_q  <= '0; bmp_q  <= '0; prot_q <= 1'b0; v86_q <= 1'b0;
      cpl_q  <= '0; iopl_q <= '0; chk_q  <= 1'b0; xlat_q <= 1'b0;
      base_q <= '0;
    end else if (take) begin
      port_q <= req_port;  data_q <= req_data; size_q <= req_size;
      dir_q  <= req_dir;   idx_q  <= req_idx;  bmp_q  <= req_bmp;
      prot_q <= prot_en;   v86_q  <= v86_en;   cpl_q  <= cpl;
      iopl_q <= iopl;      chk_q  <= io_chk_en; xlat_q <= xlat_en;
      base_q <= io_base;
    end
  end

  spout_perm #(.PL_W(2), .BM_W(4)) perm_i (
    .prot_en(prot_q), .v86_en(v86_q), .cpl(cpl_q), .iopl(iopl_q),
    .io_chk_en(chk_q), .size(size_q), .bmp(bmp_q), .deny(deny)
  );

  spout_addr #(.VA_W(VA_W), .IMPL_VA_W(IMPL_VA_W)) addr_i (
    .io_base(base_q), .port(port_q), .xlat_en(xlat_q), .va(va), .bad(bad)
  );

  spout_idx #(.IDX_W(IDX_W)) idx_i (
    .idx(idx_q), .size(size_q), .dir(dir_q), .idx_nxt(idx_nxt)
  );

  assign fault = deny || bad;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_valid)  state_d = ST_CHECK;
      ST_CHECK:      state_d = fault ? ST_IDLE : ST_FENCE_PRE;
      ST_FENCE_PRE:  if (fence_done) state_d = ST_WRITE;
      ST_WRITE:      if (wr_ready)   state_d = ST_FENCE_POST;
      ST_FENCE_POST: if (fence_done) state_d = ST_UPDATE;
      ST_UPDATE:     state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign fault_valid = (state_q == ST_CHECK) && fault;
  assign fault_code  = 16'h0000;
  assign fence_req   = (state_q == ST_FENCE_PRE) || (state_q == ST_FENCE_POST);
  assign wr_valid    = (state_q == ST_WRITE);
  assign wr_addr     = va;
  assign wr_data     = data_q;
  assign wr_size     = size_q;
  assign idx_valid   = (state_q == ST_UPDATE);
  assign idx_out     = idx_nxt;

  // Checks
  assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    fault_valid |=> !fault_valid);

  assert_write_after_fence_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(wr_valid) |-> $past(fence_req && fence_done));

  assert_idx_after_fence_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    idx_valid |-> $past(fence_req && fence_done));

  assert_impl_addr_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_valid |-> ((wr_addr >> IMPL_VA_W) == '0));

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

endmodule

// File: tb/spout_unit_tb.sv
`timescale 1ns/1ps
module spout_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [15:0] req_port;
  logic [31:0] req_data;
  logic [1:0]  req_size;
  logic        req_dir;
  logic [31:0] req_idx;
  logic [3:0]  req_bmp;
  logic        prot_en, v86_en, io_chk_en, xlat_en;
  logic [1:0]  cpl, iopl;
  logic [63:0] io_base;
  logic        fault_valid;
  logic [15:0] fault_code;
  logic        fence_req, fence_done;
  logic        wr_valid, wr_ready;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  wr_size;
  logic        idx_valid;
  logic [31:0] idx_out;

  always #2 clk = ~clk;

  spout_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_data(req_data), .req_size(req_size),
    .req_dir(req_dir), .req_idx(req_idx), .req_bmp(req_bmp),
    .prot_en(prot_en), .v86_en(v86_en), .cpl(cpl), .iopl(iopl),
    .io_chk_en(io_chk_en), .xlat_en(xlat_en), .io_base(io_base),
    .fault_valid(fault_valid), .fault_code(fault_code),
    .fence_req(fence_req), .fence_done(fence_done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_size(wr_size),
    .idx_valid(idx_valid), .idx_out(idx_out)
  );

  typedef struct packed {
    logic [15:0] port;
    logic [31:0] data;
    logic [1:0]  size;
    logic        prot;
    logic        v86;
    logic [1:0]  cpl;
    logic [1:0]  iopl;
    logic        chk;
    logic        xlat;
    logic        dir;
    logic [3:0]  bmp;
    logic [63:0] base;
    logic        exp_fault;
  } vec_t;

  localparam logic [63:0] BASE = 64'h0000_1234_0000_0000;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // port     data          sz  pe  v86 cpl  iopl chk xl dir bmp     base   fault
    '{16'h03F8, 32'h0000_00A5, 2'd0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 4'b1111, BASE, 1'b0}, // R1 real mode
    '{16'h0061, 32'h0000_BEEF, 2'd1, 1'b1, 1'b0, 2'd3, 2'd0, 1'b1, 1'b1, 1'b1, 4'b0100, BASE, 1'b0}, // R3 word mask
    '{16'h0070, 32'h1122_3344, 2'd2, 1'b1, 1'b0, 2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 4'b1000, BASE, 1'b1}, // R3 dword deny
    '{16'h0080, 32'h0000_0011, 2'd0, 1'b1, 1'b0, 2'd3, 2'd0, 1'b0, 1'b1, 1'b1, 4'b1111, BASE, 1'b0}, // R2 check off
    '{16'h0081, 32'h0000_0022, 2'd0, 1'b1, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 4'b0001, BASE, 1'b0}, // R1 cpl<=iopl
    '{16'h0082, 32'h0000_0033, 2'd0, 1'b1, 1'b1, 2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 4'b0001, BASE, 1'b1}, // R1 v86
    '{16'hFFFF, 32'hCAFE_F00D, 2'd2, 1'b1, 1'b0, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 4'b0000, BASE, 1'b0}, // R4 top port
    '{16'h0100, 32'h0000_5555, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0000, BASE, 1'b1}, // R5 xlat off
    '{16'h0200, 32'h0000_0077, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 4'b0000,
      64'h0100_0000_0000_0000, 1'b1},                                                                   // R5 high bit
    '{16'h1235, 32'h8765_4321, 2'd2, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 4'b0000, BASE, 1'b0}  // R7 dword down
  };

  int checks = 0;
  int errors = 0;
  int fences;
  int fcyc;
  int fence_delay;
  logic hold_wr;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(input logic [63:0] b, input logic [15:0] p);
    logic [63:0] pg;
    pg = 64'(p[15:2]) * 64'd4096;
    return b | pg | 64'(p[11:0]);
  endfunction

  function automatic logic [31:0] exp_idx(input logic [31:0] i, input logic [1:0] s, input logic d);
    int st;
    st = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    return d ? i - 32'(st) : i + 32'(st);
  endfunction

  // Fence responder and write stall, run at negedges by the monitor.
  task automatic tick_resp();
    if (fence_req) begin
      fcyc++;
      if (fcyc > fence_delay) begin
        fence_done = 1'b1;
        fences++;
        fcyc = 0;
      end else fence_done = 1'b0;
    end else begin
      fence_done = 1'b0;
      fcyc = 0;
    end
  endtask

  task automatic run(input vec_t v, input string tag);
    logic        got_f, got_w, got_i, early_w, second_f;
    logic [63:0] w_addr;
    logic [31:0] w_data, i_val;
    logic [1:0]  w_size;
    logic [15:0] f_code;
    int          fb, fa;
    got_f = 0; got_w = 0; got_i = 0; early_w = 0; second_f = 0;
    w_addr = '0; w_data = '0; i_val = '0; w_size = '0; f_code = '1; fb = 0; fa = 0;
    fences = 0; fcyc = 0;
    req_port = v.port; req_data = v.data; req_size = v.size; req_dir = v.dir;
    req_idx = 32'h0000_1000; req_bmp = v.bmp; prot_en = v.prot; v86_en = v.v86;
    cpl = v.cpl; iopl = v.iopl; io_chk_en = v.chk; xlat_en = v.xlat; io_base = v.base;
    req_valid = 1'b1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (got_f) begin
        second_f = fault_valid;
        break;
      end
      if (fault_valid) begin got_f = 1; f_code = fault_code; end
      if (wr_valid && fences == 0) early_w = 1;
      if (wr_valid && !got_w) begin
        got_w = 1; w_addr = wr_addr; w_data = wr_data; w_size = wr_size; fb = fences;
      end
      if (idx_valid) begin got_i = 1; i_val = idx_out; fa = fences; end
      tick_resp();
      if (got_i) break;
    end
    fence_done = 1'b0;
    chk(got_f == v.exp_fault, "R3", {tag, " fault"}, 64'(got_f), 64'(v.exp_fault));
    if (v.exp_fault) begin
      chk(f_code == 16'h0, "R9", {tag, " code"}, 64'(f_code), 64'h0);
      chk(!got_w && !got_i && fences == 0, "R9", {tag, " no side effect"},
          64'({got_w, got_i}), 64'h0);
      chk(!second_f, "R9", {tag, " single pulse"}, 64'(second_f), 64'h0);
      chk(req_ready, "R9", {tag, " back to idle"}, 64'(req_ready), 64'h1);
    end else begin
      chk(w_addr == exp_addr(v.base, v.port), "R4", {tag, " addr"}, w_addr, exp_addr(v.base, v.port));
      chk(w_data == v.data && w_size == v.size, "R4", {tag, " data"}, 64'(w_data), 64'(v.data));
      chk(!early_w && fb == 1, "R6", {tag, " fence before write"}, 64'(fb), 64'h1);
      chk(got_i && fa == 2, "R6", {tag, " fence after write"}, 64'(fa), 64'h2);
      chk(i_val == exp_idx(32'h1000, v.size, v.dir), "R7", {tag, " index"},
          64'(i_val), 64'(exp_idx(32'h1000, v.size, v.dir)));
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; fence_done = 1'b0; wr_ready = 1'b1; hold_wr = 1'b0;
    req_port = '0; req_data = '0; req_size = '0; req_dir = 1'b0; req_idx = '0;
    req_bmp = '0; prot_en = 1'b0; v86_en = 1'b0; cpl = '0; iopl = '0;
    io_chk_en = 1'b0; xlat_en = 1'b1; io_base = '0; fence_delay = 0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(req_ready && !fault_valid && !fence_req && !wr_valid && !idx_valid, "R10",
        "reset outputs", 64'({req_ready, fault_valid, fence_req, wr_valid, idx_valid}), 64'h10);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req_ready, "R8", "ready when idle", 64'(req_ready), 64'h1);

    for (int k = 0; k < NV; k++) run(VECS[k], $sformatf("vec%0d", k));

    // R6: slow fences must hold off write and index result
    fence_delay = 4;
    run(VECS[0], "slow fence");
    fence_delay = 0;

    // R8: stalled write keeps address/data; ready low while busy
    begin
      logic [63:0] a0;
      logic        stable_ok;
      logic        busy_ok;
      stable_ok = 1; busy_ok = 1;
      wr_ready = 1'b0;
      req_port = 16'h0444; req_data = 32'h0BAD_CAFE; req_size = 2'd1; req_dir = 1'b0;
      req_idx = 32'h20; req_bmp = 4'b0; prot_en = 1'b0; v86_en = 1'b0;
      io_chk_en = 1'b0; xlat_en = 1'b1; io_base = BASE;
      fences = 0; fcyc = 0;
      req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0; tick_resp();
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (req_ready) busy_ok = 0;
        tick_resp();
      end
      a0 = wr_addr;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (!wr_valid || wr_addr != a0 || wr_data != 32'h0BAD_CAFE) stable_ok = 0;
      end
      chk(stable_ok && a0 == exp_addr(BASE, 16'h0444), "R8", "held write stable",
          a0, exp_addr(BASE, 16'h0444));
      chk(busy_ok, "R8", "not ready while busy", 64'(busy_ok), 64'h1);
      wr_ready = 1'b1;
      for (int c = 0; c < 6; c++) begin @(negedge clk); tick_resp(); end
      fence_done = 1'b0;
    end

    // R10: reset in the middle of an operation (fence never completes)
    fence_delay = 1000;
    fences = 0; fcyc = 0;
    req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) begin @(negedge clk); tick_resp(); end
    chk(fence_req, "R6", "waiting on fence", 64'(fence_req), 64'h1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !fence_req && !wr_valid && !idx_valid, "R10", "mid-op reset",
        64'({req_ready, fence_req, wr_valid, idx_valid}), 64'h8);
    fence_delay = 0; fence_done = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run(VECS[6], "after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule